// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block holds one small status word per DMA channel and turns those words into interrupt requests. Each word carries two sticky flags, transfer completion and transfer error, which software clears by writing ones. It also carries two live flags that show whether the channel is running and whether it is fetching a descriptor. The DMA engine reports what happens through single-cycle event pulses: work unit done, error, descriptor fetch start and end, channel stop, and a write to the channel's configuration with its enable bit and flow mode. Software reaches the words through a plain register port with one word per channel address.

Each channel has its own data interrupt line, driven by its completion flag. The error flags of every channel are ORed into one global error interrupt on a separate line. Software finds the failing channel by reading the status words one by one.

Top module: `dma_irq_status_agg`

## Requirements
- R1: While reset is asserted and after it, every status word reads 0x0000 and all interrupt outputs are low.
- R2: A done pulse on channel k sets bit 0 of its word on the next clock edge; `irq_data_o[k]` equals that bit.
- R3: Writing a word with bit 0 or bit 1 at 1 clears that flag; writing 0 to either leaves it unchanged.
- R4: An error pulse on channel k sets bit 1 of its word; `irq_err_o` is high exactly while any channel's bit 1 is set.
- R5: Bit 3 (running) is set by a config write with the enable bit (cfg_en) at 1, for any flow mode, and cleared by a stop pulse or a config write with enable 0.
- R6: Bit 2 (descriptor fetch) is loaded by an enabling config write with 1 only for flow modes 4 to 7 (0 for modes 0 to 3), set by a fetch-start pulse while running, cleared by fetch-end, stop or a disabling config write.
- R7: Bits 15:4 always read 0; writes to bits 2 and 3 or to bits 15:4 have no effect.
- R8: When a setting event and a clearing action hit the same bit in one cycle, the bit ends set (config write beats stop, fetch start beats fetch end, event beats software clear).
- R9: A write or event on one channel changes no other channel's word or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_done_i | input | NCH | Work-unit-done pulse per channel |
| ev_err_i | input | NCH | DMA error pulse per channel |
| ev_fetch_start_i | input | NCH | Descriptor fetch begins |
| ev_fetch_end_i | input | NCH | Descriptor fetch finished |
| ev_stop_i | input | NCH | Channel stopped |
| cfg_wr_i | input | NCH | Config register written |
| cfg_en_i | input | NCH | Enable bit of the config write |
| cfg_flow_i | input | NCH*FLOW_W | Flow mode of the config write, channel k at bits k*FLOW_W |
| reg_addr_i | input | AW | Channel index of the register access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Status word of the addressed channel |
| irq_data_o | output | NCH | Per-channel completion interrupt |
| irq_err_o | output | 1 | Global DMA error interrupt |

## Verification
The hardest situations to reach are those where hardware and software act on one flag in the same cycle, or two live-flag events collide, because the engine and software normally act cycles apart. The directed part of the bench drives the event pulse and the register write (or the paired events) in one cycle and reads the word back afterwards. A second hard case is a global error kept alive by one channel while another is cleared; the bench raises errors on two channels together and clears them one at a time.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int FLOW_W         = 3;
  localparam int FETCH_FLOW_MIN = 4;
  localparam int STAT_W         = 4;
  localparam int BIT_DONE       = 0;
  localparam int BIT_ERR        = 1;

  // Packed MSB first: bit3 running, bit2 fetch, bit1 error, bit0 done.
  typedef struct packed {
    logic run;
    logic fetch;
    logic err;
    logic done;
  } chan_stat_t;
endpackage

// File: rtl/dma_irq_rst_sync.sv
module dma_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              ev_done,
  input  logic              ev_err,
  input  logic              ev_fetch_start,
  input  logic              ev_fetch_end,
  input  logic              ev_stop,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [FLOW_W-1:0] cfg_flow,
  input  logic              clr_done,
  input  logic              clr_err,
  output chan_stat_t        stat_o
);
  chan_stat_t stat_q, stat_d;
  logic       upd;

  // Clock enable: the word only moves when something touches it.
  assign upd = ev_done | ev_err | ev_fetch_start | ev_fetch_end | ev_stop
             | cfg_wr | clr_done | clr_err;

  always_comb begin
    stat_d = stat_q;
    // Sticky flags: hardware set wins over software clear.
    stat_d.done = ev_done | (stat_q.done & ~clr_done);
    stat_d.err  = ev_err  | (stat_q.err  & ~clr_err);
    // Live flags: config write first, then stop, then fetch events.
    if (cfg_wr) begin
      stat_d.run   = cfg_en;
      stat_d.fetch = cfg_en & (cfg_flow >= FLOW_W'(FETCH_FLOW_MIN));
    end else if (ev_stop) begin
      stat_d.run   = 1'b0;
      stat_d.fetch = 1'b0;
    end else if (ev_fetch_start & stat_q.run) begin
      stat_d.fetch = 1'b1;
    end else if (ev_fetch_end) begin
      stat_d.fetch = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic [NCH*STAT_W-1:0] stat_flat_i,
  input  logic [NCH-1:0]        sel_i,
  output logic [DW-1:0]         rdata_o
);
  logic [STAT_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_i[i]) word = word | stat_flat_i[i*STAT_W +: STAT_W];
    end
    rdata_o = '0;
    rdata_o[STAT_W-1:0] = word;
  end
endmodule

// File: rtl/dma_irq_status_agg.sv
module dma_irq_status_agg
  import dma_irq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        ev_done_i,
  input  logic [NCH-1:0]        ev_err_i,
  input  logic [NCH-1:0]        ev_fetch_start_i,
  input  logic [NCH-1:0]        ev_fetch_end_i,
  input  logic [NCH-1:0]        ev_stop_i,
  input  logic [NCH-1:0]        cfg_wr_i,
  input  logic [NCH-1:0]        cfg_en_i,
  input  logic [NCH*FLOW_W-1:0] cfg_flow_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [DW-1:0]         reg_wdata_i,
  output logic [DW-1:0]         reg_rdata_o,
  output logic [NCH-1:0]        irq_data_o,
  output logic                  irq_err_o
);
  logic                  rst_sync_n;
  logic [NCH-1:0]        sel;
  logic [NCH-1:0]        err_vec;
  logic [NCH*STAT_W-1:0] stat_flat;
  logic                  unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DW-1:2];

  dma_irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    chan_stat_t st;

    assign sel[g] = (reg_addr_i == AW'(g));

    dma_irq_chan u_chan (
      .clk           (clk),
      .rst_ni        (rst_sync_n),
      .ev_done       (ev_done_i[g]),
      .ev_err        (ev_err_i[g]),
      .ev_fetch_start(ev_fetch_start_i[g]),
      .ev_fetch_end  (ev_fetch_end_i[g]),
      .ev_stop       (ev_stop_i[g]),
      .cfg_wr        (cfg_wr_i[g]),
      .cfg_en        (cfg_en_i[g]),
      .cfg_flow      (cfg_flow_i[g*FLOW_W +: FLOW_W]),
      .clr_done      (reg_wr_i & sel[g] & reg_wdata_i[BIT_DONE]),
      .clr_err       (reg_wr_i & sel[g] & reg_wdata_i[BIT_ERR]),
      .stat_o        (st)
    );

    assign stat_flat[g*STAT_W +: STAT_W] = st;
    assign irq_data_o[g] = st.done;
    assign err_vec[g]    = st.err;
  end

  assign irq_err_o = |err_vec;

  dma_irq_rdmux #(.NCH(NCH), .DW(DW)) u_rdmux (
    .stat_flat_i(stat_flat),
    .sel_i      (sel),
    .rdata_o    (reg_rdata_o)
  );
endmodule

// File: rtl/dma_irq_status_agg_chk.sv
module dma_irq_status_agg_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ev_done_i,
  input logic [NCH-1:0] ev_err_i,
  input logic [AW-1:0]  reg_addr_i,
  input logic           reg_wr_i,
  input logic [DW-1:0]  reg_wdata_i,
  input logic [DW-1:0]  reg_rdata_o,
  input logic [NCH-1:0] irq_data_o,
  input logic           irq_err_o
);
  logic [AW-1:0] addr_q;
  always_ff @(posedge clk) addr_q <= reg_addr_i;

  p_done_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_i != '0) |=> ((irq_data_o & $past(ev_done_i)) == $past(ev_done_i)));

  p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_err_i) |=> irq_err_o);

  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_err_o && ev_err_i == '0 && !reg_wr_i) |=> irq_err_o);

  p_done_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_wdata_i[0] && ev_done_i == '0) |=> !irq_data_o[addr_q]);

  p_irq_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_i == '0 && !reg_wr_i) |=> $stable(irq_data_o));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o >> 4) == '0);
endmodule

bind dma_irq_status_agg dma_irq_status_agg_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ev_done_i  (ev_done_i),
  .ev_err_i   (ev_err_i),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_data_o (irq_data_o),
  .irq_err_o  (irq_err_o)
);

// File: tb/dma_irq_status_agg_tb.sv
module dma_irq_status_agg_tb;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int FW  = 3;
  localparam int AW  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_ni;
  logic [NCH-1:0]   ev_done, ev_err, ev_fs, ev_fe, ev_stop, cfg_wr, cfg_en;
  logic [NCH*FW-1:0] cfg_flow;
  logic [AW-1:0]    reg_addr;
  logic             reg_wr;
  logic [DW-1:0]    reg_wdata, reg_rdata;
  logic [NCH-1:0]   irq_data;
  logic             irq_err;

  dma_irq_status_agg #(.NCH(NCH), .DW(DW)) u_dut (
    .clk(clk), .rst_ni(rst_ni),
    .ev_done_i(ev_done), .ev_err_i(ev_err), .ev_fetch_start_i(ev_fs),
    .ev_fetch_end_i(ev_fe), .ev_stop_i(ev_stop), .cfg_wr_i(cfg_wr),
    .cfg_en_i(cfg_en), .cfg_flow_i(cfg_flow), .reg_addr_i(reg_addr),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_data_o(irq_data), .irq_err_o(irq_err)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // op: 1 done, 2 err, 3 fetch start, 4 fetch end, 5 stop,
  //     6 config write (arg[3] enable, arg[2:0] flow), 7 register write
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ch;
    logic [15:0] arg;
    logic [15:0] word;
    logic [3:0]  irq;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [17] = '{
    '{3'd6, 2'd0, 16'h0009, 16'h0008, 4'h0, 1'b0, 4'd5}, // R5 enable flow 1
    '{3'd6, 2'd1, 16'h000D, 16'h000C, 4'h0, 1'b0, 4'd6}, // R6 enable flow 5
    '{3'd4, 2'd1, 16'h0000, 16'h0008, 4'h0, 1'b0, 4'd6}, // R6 fetch end
    '{3'd3, 2'd1, 16'h0000, 16'h000C, 4'h0, 1'b0, 4'd6}, // R6 fetch start
    '{3'd5, 2'd1, 16'h0000, 16'h0000, 4'h0, 1'b0, 4'd5}, // R5 stop
    '{3'd1, 2'd2, 16'h0000, 16'h0001, 4'h4, 1'b0, 4'd2}, // R2 done
    '{3'd2, 2'd3, 16'h0000, 16'h0002, 4'h4, 1'b1, 4'd4}, // R4 error
    '{3'd7, 2'd2, 16'h0000, 16'h0001, 4'h4, 1'b1, 4'd3}, // R3 zero write
    '{3'd7, 2'd2, 16'hFFFE, 16'h0001, 4'h4, 1'b1, 4'd7}, // R7 R9 ignored bits
    '{3'd7, 2'd2, 16'h0001, 16'h0000, 4'h0, 1'b1, 4'd3}, // R3 clear done
    '{3'd7, 2'd3, 16'h0002, 16'h0000, 4'h0, 1'b0, 4'd3}, // R3 clear error
    '{3'd2, 2'd0, 16'h0000, 16'h000A, 4'h0, 1'b1, 4'd4}, // R4 error while running
    '{3'd6, 2'd0, 16'h0005, 16'h0002, 4'h0, 1'b1, 4'd5}, // R5 disabling write
    '{3'd7, 2'd0, 16'h0002, 16'h0000, 4'h0, 1'b0, 4'd3}, // R3
    '{3'd6, 2'd3, 16'h000F, 16'h000C, 4'h0, 1'b0, 4'd6}, // R6 flow 7
    '{3'd6, 2'd3, 16'h0008, 16'h0008, 4'h0, 1'b0, 4'd6}, // R6 flow 0
    '{3'd6, 2'd2, 16'h000C, 16'h000C, 4'h0, 1'b0, 4'd6}  // R6 flow 4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ev_done = '0; ev_err = '0; ev_fs = '0; ev_fe = '0; ev_stop = '0;
    cfg_wr = '0; cfg_en = '0; cfg_flow = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic rd(input int ch, output logic [DW-1:0] w);
    reg_addr = AW'(ch);
    #0.5;
    w = reg_rdata;
  endtask

  task automatic set_op(input logic [2:0] op, input int ch, input logic [15:0] arg);
    case (op)
      3'd1: ev_done[ch] = 1'b1;
      3'd2: ev_err[ch]  = 1'b1;
      3'd3: ev_fs[ch]   = 1'b1;
      3'd4: ev_fe[ch]   = 1'b1;
      3'd5: ev_stop[ch] = 1'b1;
      3'd6: begin
        cfg_wr[ch] = 1'b1;
        cfg_en[ch] = arg[3];
        cfg_flow[ch*FW +: FW] = arg[2:0];
      end
      3'd7: begin
        reg_wr = 1'b1; reg_addr = AW'(ch); reg_wdata = arg;
      end
      default: ;
    endcase
  endtask

  logic [DW-1:0] w;

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    reg_addr = '0;
    rst_ni = 1'b0;
    repeat (3) tick();
    for (int c = 0; c < NCH; c++) begin
      rd(c, w); chk("R1 reset word", w, 0);
    end
    chk("R1 reset irq_data", irq_data, 0);
    chk("R1 reset irq_err", irq_err, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (4) tick();

    for (int i = 0; i < 17; i++) begin
      set_op(TBL[i].op, int'(TBL[i].ch), TBL[i].arg);
      tick();
      rd(int'(TBL[i].ch), w);
      chk($sformatf("R%0d step %0d word", TBL[i].req, i), w, TBL[i].word);
      chk($sformatf("R%0d step %0d irq_data", TBL[i].req, i), irq_data, TBL[i].irq);
      chk($sformatf("R%0d step %0d irq_err", TBL[i].req, i), irq_err, TBL[i].err);
    end

    // R8: done event and software clear in one cycle
    set_op(3'd1, 1, 0); set_op(3'd7, 1, 16'h0001); tick();
    rd(1, w); chk("R8 done set beats clear", w, 16'h0001);
    chk("R8 irq_data after collide", irq_data, 4'h2);
    set_op(3'd7, 1, 16'h0001); tick();
    rd(1, w); chk("R3 done cleared", w, 0);

    // R8: error event and software clear in one cycle
    set_op(3'd2, 0, 0); set_op(3'd7, 0, 16'h0002); tick();
    rd(0, w); chk("R8 err set beats clear", w, 16'h0002);
    chk("R8 irq_err after collide", irq_err, 1);
    set_op(3'd7, 0, 16'h0002); tick();

    // R8: enabling config write and stop together
    set_op(3'd6, 0, 16'h0009); set_op(3'd5, 0, 0); tick();
    rd(0, w); chk("R8 R5 config beats stop", w, 16'h0008);

    // R8: fetch start and fetch end together
    set_op(3'd3, 0, 0); set_op(3'd4, 0, 0); tick();
    rd(0, w); chk("R8 R6 fetch start beats end", w, 16'h000C);

    // R6: fetch start on an idle channel has no effect
    set_op(3'd3, 1, 0); tick();
    rd(1, w); chk("R6 fetch start while idle", w, 0);

    // R9 R4: two channels in error, cleared one by one
    set_op(3'd2, 1, 0); set_op(3'd2, 3, 0); tick();
    chk("R4 two errors", irq_err, 1);
    set_op(3'd7, 1, 16'h0002); tick();
    rd(1, w); chk("R9 ch1 cleared", w, 0);
    rd(3, w); chk("R9 ch3 untouched", w, 16'h000A);
    chk("R4 error still held", irq_err, 1);
    set_op(3'd7, 3, 16'h0002); tick();
    chk("R4 error released", irq_err, 0);
    rd(3, w); chk("R9 ch3 running kept", w, 16'h0008);

    // R1: reset in the middle of activity
    set_op(3'd1, 2, 0); tick();
    rst_ni = 1'b0; #1;
    for (int c = 0; c < NCH; c++) begin
      rd(c, w); chk("R1 mid-run reset word", w, 0);
    end
    chk("R1 mid-run reset irq_data", irq_data, 0);
    chk("R1 mid-run reset irq_err", irq_err, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule